// File: doc/BRIEF.md
# EDO DRAM Bus Cycle Classifier

This block watches the four control strobes of an EDO DRAM bus (row strobe, column strobe, write enable and output enable, all active low) without driving anything on that bus. The strobes are brought into the local clock domain through a short flop chain. From then on the block works from the order in which the strobe edges arrive, not from static levels. For each period in which the row strobe is low, it reports one cycle type when the row strobe rises. The report carries the number of column-strobe cycles seen in that period.

The block also models when the memory would drive its data pins. It flags one ordering fault: output enable still asserted at the moment write enable falls during a read access. A system monitor or protocol checker would use it to label bus traffic and catch controller sequencing errors. Timing margins finer than one sample clock are not resolved.

When both strobes appear to fall in the same sample, the column strobe is treated as first. Page-mode periods take their type from the first column access in the period.

Top module: `edo_cycle_classifier`

## Requirements
- R1: While reset is held (synchronous, active low) and after it is released with all strobes high, `cyc_valid` and `order_err` are 0, `cyc_code` is 0 (standby), `page_cnt` is 0 and `dq_drive` is 0.
- R2: A period whose first column access begins with write enable high and sees no write-enable fall while the column strobe is low is reported with code 1 (read).
- R3: A period whose first column access begins with write enable already low is reported with code 2 (early write), and `dq_drive` stays 0 throughout it.
- R4: A period whose first access begins with write enable high, where write enable then falls while the column strobe is low and output enable was not seen low, is reported with code 3 (delayed write).
- R5: The same sequence as R4, but with output enable seen low before write enable falls, is reported with code 4 (read-modify-write).
- R6: A period in which the row strobe falls and rises again while the column strobe stays high is reported with code 5 (row-only refresh) and a count of 0.
- R7: A period in which the row strobe falls while the column strobe is low, when the column strobe fell while the row strobe was high, is reported with code 6 (column-before-row refresh).
- R8: A period in which the row strobe falls while the column strobe has been held low since the previous row-strobe rise is reported with code 7 (hidden refresh). During this period `dq_drive` keeps the data read in the preceding period.
- R9: `page_cnt` reports the number of column-strobe falls seen while the row strobe was low in the period, saturating at 2^CNT_W-1. The cycle type comes from the first of those accesses.
- R10: `dq_drive` goes high when a read access is open and output enable is low. It holds after the column strobe rises while the row strobe stays low. It drops once both strobes are high, output enable is high, or write enable falls.
- R11: `order_err` pulses for one cycle when write enable falls during an open read access while output enable is low.
- R12: `cyc_valid` pulses for exactly one cycle per row-strobe rise. `cyc_code` and `page_cnt` hold their values between pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| cyc_valid | output | 1 | One-cycle pulse when a period's report is updated |
| cyc_code | output | 3 | Cycle type: 0 standby, 1 read, 2 early write, 3 delayed write, 4 read-modify-write, 5 row-only refresh, 6 column-before-row refresh, 7 hidden refresh |
| page_cnt | output | CNT_W | Column accesses in the reported period |
| dq_drive | output | 1 | High while the memory would drive read data |
| order_err | output | 1 | One-cycle pulse on an output-enable ordering fault |

## Verification
The checks assume that strobe edges are separated by several sample clocks. An edge of write enable, the column strobe and the row strobe is never expected in the same sample. The stimulus therefore changes one strobe at a time and holds each step for six clocks, which is longer than the synchronizer and edge pipeline. Tie cases, such as both strobes falling together, are left to the documented priority rules and are not exercised.

// File: rtl/edo_cls_pkg.sv
// Package: shared strobe indices and cycle-type encodings for the classifier.
// Assumes the strobe vector is packed {ras, cas, we, oe}, all active low.
package edo_cls_pkg;
    localparam int NSIG    = 4;
    localparam int SIG_OE  = 0;
    localparam int SIG_WE  = 1;
    localparam int SIG_CAS = 2;
    localparam int SIG_RAS = 3;

    typedef enum logic [2:0] {
        CY_STANDBY    = 3'd0,
        CY_READ       = 3'd1,
        CY_EARLY_WR   = 3'd2,
        CY_DELAYED_WR = 3'd3,
        CY_RMW        = 3'd4,
        CY_RAS_ONLY   = 3'd5,
        CY_CBR        = 3'd6,
        CY_HIDDEN     = 3'd7
    } cyc_kind_t;

    typedef enum logic [1:0] {
        REF_NONE   = 2'd0,
        REF_CBR    = 2'd1,
        REF_HIDDEN = 2'd2
    } ref_kind_t;
endpackage

// File: rtl/edo_strobe_sync.sv
// Module: brings the asynchronous strobe vector into the clock domain.
// Assumes inactive strobes read high; the chain resets to all ones.
// STAGES = 0 selects a plain pass-through for already synchronous buses.
module edo_strobe_sync #(
    parameter int STAGES = 2,
    parameter int WIDTH  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    if (STAGES == 0) begin : g_bypass
        assign sync_o = async_i;
    end else begin : g_chain
        logic [STAGES-1:0][WIDTH-1:0] chain;

        // Shift the sampled strobes through the flop chain.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                chain <= '1;
            end else begin
                chain[0] <= async_i;
                for (int i = 1; i < STAGES; i++) begin
                    chain[i] <= chain[i-1];
                end
            end
        end

        assign sync_o = chain[STAGES-1];
    end
endmodule

// File: rtl/edo_strobe_edges.sv
// Module: turns synchronized strobe levels into single-cycle edge strobes.
// Assumes active-low strobes: "fall" is assertion, "rise" is release.
// Output enable needs no edges; only its level is used downstream.
module edo_strobe_edges
    import edo_cls_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSIG-1:0] lvl,
    output logic            ras_fall,
    output logic            ras_rise,
    output logic            cas_fall,
    output logic            cas_rise,
    output logic            we_fall
);
    logic ras_q, cas_q, we_q;

    // Remember last sample of the edge-relevant strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ras_q <= 1'b1;
            cas_q <= 1'b1;
            we_q  <= 1'b1;
        end else begin
            ras_q <= lvl[SIG_RAS];
            cas_q <= lvl[SIG_CAS];
            we_q  <= lvl[SIG_WE];
        end
    end

    // Compare current sample with the previous one.
    always_comb begin
        ras_fall = ras_q & ~lvl[SIG_RAS];
        ras_rise = ~ras_q & lvl[SIG_RAS];
        cas_fall = cas_q & ~lvl[SIG_CAS];
        cas_rise = ~cas_q & lvl[SIG_CAS];
        we_fall  = we_q & ~lvl[SIG_WE];
    end
endmodule

// File: rtl/edo_access_tracker.sv
// Module: follows column accesses inside one row period. Counts them
// (saturating), types the first one from the write/output-enable
// ordering, models the data-pin drive window and flags the fault of
// output enable still low when write enable falls on a read access.
// Assumes edges arrive one per sample; a row fall restarts the period.
module edo_access_tracker
    import edo_cls_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NSIG-1:0]  lvl,
    input  logic             ras_fall,
    input  logic             cas_fall,
    input  logic             cas_rise,
    input  logic             we_fall,
    output logic [CNT_W-1:0] acc_cnt,
    output cyc_kind_t        acc_type,
    output logic             dq_drive,
    output logic             order_err
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic ras_lo, cas_lo, we_lo, oe_lo;
    logic acc_start, first_acc;
    logic first_open, oe_seen, rd_hold;

    always_comb begin
        ras_lo    = ~lvl[SIG_RAS];
        cas_lo    = ~lvl[SIG_CAS];
        we_lo     = ~lvl[SIG_WE];
        oe_lo     = ~lvl[SIG_OE];
        acc_start = cas_fall & ras_lo;
        first_acc = acc_start && (acc_cnt == '0);
    end

    // Count column accesses in the current row period, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n)                             acc_cnt <= '0;
        else if (ras_fall)                      acc_cnt <= '0;
        else if (acc_start && acc_cnt != CNT_MAX) acc_cnt <= acc_cnt + 1'b1;
    end

    // Mark the window of the first column access of the period.
    always_ff @(posedge clk) begin
        if (!rst_n)         first_open <= 1'b0;
        else if (ras_fall)  first_open <= 1'b0;
        else if (first_acc) first_open <= 1'b1;
        else if (cas_rise)  first_open <= 1'b0;
    end

    // Note whether output enable was seen low during the first access.
    always_ff @(posedge clk) begin
        if (!rst_n)                              oe_seen <= 1'b0;
        else if (cas_fall)                       oe_seen <= 1'b0;
        else if (first_open && cas_lo && oe_lo)  oe_seen <= 1'b1;
    end

    // Type the first access from write-enable order relative to column fall.
    always_ff @(posedge clk) begin
        if (!rst_n)         acc_type <= CY_READ;
        else if (ras_fall)  acc_type <= CY_READ;
        else if (first_acc) acc_type <= we_lo ? CY_EARLY_WR : CY_READ;
        else if (first_open && cas_lo && we_fall && acc_type == CY_READ)
            acc_type <= oe_seen ? CY_RMW : CY_DELAYED_WR;
    end

    // Hold read data from a read access until released.
    always_ff @(posedge clk) begin
        if (!rst_n)                    rd_hold <= 1'b0;
        else if (cas_fall)             rd_hold <= ras_lo & ~we_lo;
        else if (we_fall)              rd_hold <= 1'b0;
        else if (!ras_lo && !cas_lo)   rd_hold <= 1'b0;
    end

    // Data pins driven while read data is held and output enable is low.
    always_ff @(posedge clk) begin
        if (!rst_n) dq_drive <= 1'b0;
        else        dq_drive <= rd_hold & oe_lo & ~we_lo;
    end

    // Flag write enable falling on a read access with output enable low.
    always_ff @(posedge clk) begin
        if (!rst_n) order_err <= 1'b0;
        else        order_err <= we_fall & cas_lo & rd_hold & oe_lo;
    end

    // R9
    cnt_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_cnt == CNT_MAX && !ras_fall) |=> acc_cnt == CNT_MAX);

    // R10
    drive_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dq_drive |-> $past(!(lvl[SIG_RAS] && lvl[SIG_CAS]), 2));

    // R11
    err_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        order_err |=> !order_err);
endmodule

// File: rtl/edo_period_classifier.sv
// Module: decides the type of each row period from how it opened
// (column already low or not, column held from the previous period)
// and from the access tracker, and emits the report on row-strobe rise.
// Assumes the tracker's registers settle at least one sample before rise.
module edo_period_classifier
    import edo_cls_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cas_lvl,
    input  logic             ras_fall,
    input  logic             ras_rise,
    input  logic [CNT_W-1:0] acc_cnt,
    input  cyc_kind_t        acc_type,
    output logic             cyc_valid,
    output cyc_kind_t        cyc_code,
    output logic [CNT_W-1:0] page_cnt
);
    logic      cas_carry;
    ref_kind_t ref_kind;
    cyc_kind_t next_code;

    // Track a column strobe held low across a row-strobe rise.
    always_ff @(posedge clk) begin
        if (!rst_n)        cas_carry <= 1'b0;
        else if (cas_lvl)  cas_carry <= 1'b0;
        else if (ras_rise) cas_carry <= 1'b1;
    end

    // Decide refresh kind at the row-strobe fall.
    always_ff @(posedge clk) begin
        if (!rst_n)        ref_kind <= REF_NONE;
        else if (ras_fall) begin
            if (!cas_lvl) ref_kind <= cas_carry ? REF_HIDDEN : REF_CBR;
            else          ref_kind <= REF_NONE;
        end
    end

    // Select the report code for the closing period.
    always_comb begin
        case (ref_kind)
            REF_CBR:    next_code = CY_CBR;
            REF_HIDDEN: next_code = CY_HIDDEN;
            default:    next_code = (acc_cnt == '0) ? CY_RAS_ONLY : acc_type;
        endcase
    end

    // Publish the report on row-strobe rise and hold it between pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cyc_valid <= 1'b0;
            cyc_code  <= CY_STANDBY;
            page_cnt  <= '0;
        end else begin
            cyc_valid <= ras_rise;
            if (ras_rise) begin
                cyc_code <= next_code;
                page_cnt <= acc_cnt;
            end
        end
    end

    // R12
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_valid |=> !cyc_valid);
endmodule

// File: rtl/edo_cycle_classifier.sv
// Module: top of the EDO bus cycle classifier. Synchronizes the four
// strobes, derives their edges, tracks column accesses and reports one
// cycle type per row period. Passive: drives nothing onto the bus.
// Assumes strobe edges are a few sample clocks apart.
module edo_cycle_classifier
    import edo_cls_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int CNT_W       = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ras_n,
    input  logic             cas_n,
    input  logic             we_n,
    input  logic             oe_n,
    output logic             cyc_valid,
    output logic [2:0]       cyc_code,
    output logic [CNT_W-1:0] page_cnt,
    output logic             dq_drive,
    output logic             order_err
);
    logic [NSIG-1:0]  raw_vec, lvl;
    logic             ras_fall, ras_rise, cas_fall, cas_rise, we_fall;
    logic [CNT_W-1:0] acc_cnt;
    cyc_kind_t        acc_type;
    cyc_kind_t        code_q;

    assign raw_vec = {ras_n, cas_n, we_n, oe_n};

    edo_strobe_sync #(.STAGES(SYNC_STAGES), .WIDTH(NSIG)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_i(raw_vec), .sync_o(lvl)
    );

    edo_strobe_edges u_edges (
        .clk(clk), .rst_n(rst_n), .lvl(lvl),
        .ras_fall(ras_fall), .ras_rise(ras_rise),
        .cas_fall(cas_fall), .cas_rise(cas_rise), .we_fall(we_fall)
    );

    edo_access_tracker #(.CNT_W(CNT_W)) u_track (
        .clk(clk), .rst_n(rst_n), .lvl(lvl),
        .ras_fall(ras_fall), .cas_fall(cas_fall), .cas_rise(cas_rise),
        .we_fall(we_fall), .acc_cnt(acc_cnt), .acc_type(acc_type),
        .dq_drive(dq_drive), .order_err(order_err)
    );

    edo_period_classifier #(.CNT_W(CNT_W)) u_class (
        .clk(clk), .rst_n(rst_n), .cas_lvl(lvl[SIG_CAS]),
        .ras_fall(ras_fall), .ras_rise(ras_rise),
        .acc_cnt(acc_cnt), .acc_type(acc_type),
        .cyc_valid(cyc_valid), .cyc_code(code_q), .page_cnt(page_cnt)
    );

    assign cyc_code = code_q;
endmodule

// File: tb/edo_cycle_classifier_test.sv
`timescale 1ns/1ps
module edo_cycle_classifier_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic       cyc_valid, dq_drive, order_err;
    logic [2:0] cyc_code;
    logic [3:0] page_cnt;

    int n_checks = 0, n_fail = 0;
    int vcount = 0, ecount = 0, wide = 0;
    logic [2:0] last_code = 3'd0;
    logic [3:0] last_cnt = 4'd0;
    logic prev_v = 1'b0;
    bit   done = 1'b0;

    always #2.5 clk = ~clk;

    edo_cycle_classifier uut (
        .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n),
        .we_n(we_n), .oe_n(oe_n), .cyc_valid(cyc_valid),
        .cyc_code(cyc_code), .page_cnt(page_cnt),
        .dq_drive(dq_drive), .order_err(order_err)
    );

    // Row layout: [13:10] {ras,cas,we,oe}, [9] report expected,
    // [8:6] code, [5:2] count, [1] drive, [0] fault pulse expected.
    function automatic logic [13:0] rw(input logic [3:0] s, input logic v,
                                       input logic [2:0] c, input logic [3:0] n,
                                       input logic d, input logic e);
        return {s, v, c, n, d, e};
    endfunction

    localparam int NROWS = 63;
    localparam logic [13:0] ROWS [NROWS] = '{
        // read, rows 0..5
        rw(4'b0111,0,0,0,0,0), rw(4'b0011,0,0,0,0,0), rw(4'b0010,0,0,0,1,0),
        rw(4'b0110,0,0,0,1,0), rw(4'b1110,1,1,1,0,0), rw(4'b1111,0,0,0,0,0),
        // early write, rows 6..11
        rw(4'b0111,0,0,0,0,0), rw(4'b0101,0,0,0,0,0), rw(4'b0001,0,0,0,0,0),
        rw(4'b0101,0,0,0,0,0), rw(4'b1101,1,2,1,0,0), rw(4'b1111,0,0,0,0,0),
        // delayed write, rows 12..17
        rw(4'b0111,0,0,0,0,0), rw(4'b0011,0,0,0,0,0), rw(4'b0001,0,0,0,0,0),
        rw(4'b0101,0,0,0,0,0), rw(4'b1101,1,3,1,0,0), rw(4'b1111,0,0,0,0,0),
        // read-modify-write, rows 18..25
        rw(4'b0111,0,0,0,0,0), rw(4'b0011,0,0,0,0,0), rw(4'b0010,0,0,0,1,0),
        rw(4'b0011,0,0,0,0,0), rw(4'b0001,0,0,0,0,0), rw(4'b0101,0,0,0,0,0),
        rw(4'b1101,1,4,1,0,0), rw(4'b1111,0,0,0,0,0),
        // ordering fault, rows 26..32
        rw(4'b0111,0,0,0,0,0), rw(4'b0011,0,0,0,0,0), rw(4'b0010,0,0,0,1,0),
        rw(4'b0000,0,0,0,0,1), rw(4'b0100,0,0,0,0,0), rw(4'b1100,1,4,1,0,0),
        rw(4'b1111,0,0,0,0,0),
        // row-only refresh, rows 33..34
        rw(4'b0111,0,0,0,0,0), rw(4'b1111,1,5,0,0,0),
        // column-before-row refresh, rows 35..38
        rw(4'b1011,0,0,0,0,0), rw(4'b0011,0,0,0,0,0), rw(4'b1011,1,6,0,0,0),
        rw(4'b1111,0,0,0,0,0),
        // read then hidden refresh, rows 39..46
        rw(4'b0111,0,0,0,0,0), rw(4'b0011,0,0,0,0,0), rw(4'b0010,0,0,0,1,0),
        rw(4'b1010,1,1,1,1,0), rw(4'b0010,0,0,0,1,0), rw(4'b1010,1,7,0,1,0),
        rw(4'b1110,0,0,0,0,0), rw(4'b1111,0,0,0,0,0),
        // page-mode reads, rows 47..54
        rw(4'b0111,0,0,0,0,0), rw(4'b0011,0,0,0,0,0), rw(4'b0111,0,0,0,0,0),
        rw(4'b0011,0,0,0,0,0), rw(4'b0111,0,0,0,0,0), rw(4'b0011,0,0,0,0,0),
        rw(4'b0111,0,0,0,0,0), rw(4'b1111,1,1,3,0,0),
        // page mix: early write first, then read, rows 55..62
        rw(4'b0111,0,0,0,0,0), rw(4'b0101,0,0,0,0,0), rw(4'b0001,0,0,0,0,0),
        rw(4'b0101,0,0,0,0,0), rw(4'b0111,0,0,0,0,0), rw(4'b0011,0,0,0,0,0),
        rw(4'b0111,0,0,0,0,0), rw(4'b1111,1,2,2,0,0)
    };

    function automatic string tag_of(input int i);
        if (i < 6)  return "R2";
        if (i < 12) return "R3";
        if (i < 18) return "R4";
        if (i < 26) return "R5";
        if (i < 33) return "R11";
        if (i < 35) return "R6";
        if (i < 39) return "R7";
        if (i < 47) return "R8";
        return "R9";
    endfunction

    // Monitor outputs away from the active edge.
    always @(negedge clk) begin
        if (cyc_valid) begin
            vcount++;
            last_code = cyc_code;
            last_cnt  = page_cnt;
            if (prev_v) wide++;
        end
        prev_v = cyc_valid;
        if (order_err) ecount++;
    end

    task automatic chk(input bit ok, input string msg);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s", msg);
        end
    endtask

    task automatic apply(input logic [3:0] s);
        @(negedge clk);
        {ras_n, cas_n, we_n, oe_n} = s;
        repeat (6) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic finish_run;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, got hang expected completion");
            finish_run();
        end
    end

    initial begin
        int v0, e0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        // R1: outputs while reset is held
        chk(cyc_valid == 0 && dq_drive == 0 && order_err == 0,
            $sformatf("R1 in reset flags got %0b%0b%0b expected 000", cyc_valid, dq_drive, order_err));
        rst_n = 1'b1;
        repeat (6) @(posedge clk);
        @(negedge clk);
        chk(cyc_code == 3'd0, $sformatf("R1 code got %0d expected 0", cyc_code));
        chk(page_cnt == 4'd0, $sformatf("R1 count got %0d expected 0", page_cnt));
        chk(dq_drive == 1'b0, $sformatf("R1 drive got %0b expected 0", dq_drive));
        chk(cyc_valid == 1'b0 && order_err == 1'b0,
            $sformatf("R1 pulses got %0b%0b expected 00", cyc_valid, order_err));

        // Table walk
        for (int i = 0; i < NROWS; i++) begin
            logic [13:0] r;
            string tg;
            r  = ROWS[i];
            tg = tag_of(i);
            v0 = vcount;
            e0 = ecount;
            apply(r[13:10]);
            chk(dq_drive == r[1],
                $sformatf("%s/R10 row %0d drive got %0b expected %0b", tg, i, dq_drive, r[1]));
            chk((vcount - v0) == int'(r[9]),
                $sformatf("%s/R12 row %0d reports got %0d expected %0d", tg, i, vcount - v0, r[9]));
            chk((ecount - e0) == int'(r[0]),
                $sformatf("%s/R11 row %0d faults got %0d expected %0d", tg, i, ecount - e0, r[0]));
            if (r[9]) begin
                chk(last_code == r[8:6],
                    $sformatf("%s row %0d code got %0d expected %0d", tg, i, last_code, r[8:6]));
                chk(last_cnt == r[5:2],
                    $sformatf("%s row %0d count got %0d expected %0d", tg, i, last_cnt, r[5:2]));
            end
        end

        // R9: counter saturates at 15 after 17 column accesses
        v0 = vcount;
        apply(4'b0111);
        for (int k = 0; k < 17; k++) begin
            apply(4'b0011);
            apply(4'b0111);
        end
        apply(4'b1111);
        chk(vcount - v0 == 1, $sformatf("R9 saturation reports got %0d expected 1", vcount - v0));
        chk(last_cnt == 4'd15, $sformatf("R9 saturation count got %0d expected 15", last_cnt));
        chk(last_code == 3'd1, $sformatf("R9 saturation code got %0d expected 1", last_code));

        // R12: report holds between pulses
        repeat (10) @(posedge clk);
        @(negedge clk);
        chk(cyc_code == 3'd1 && page_cnt == 4'd15,
            $sformatf("R12 held report got %0d/%0d expected 1/15", cyc_code, page_cnt));
        chk(wide == 0, $sformatf("R12 wide pulses got %0d expected 0", wide));

        // R1: reset during an active read clears the outputs
        apply(4'b0111);
        apply(4'b0011);
        apply(4'b0010);
        chk(dq_drive == 1'b1, $sformatf("R10 pre-reset drive got %0b expected 1", dq_drive));
        rst_n = 1'b0;
        {ras_n, cas_n, we_n, oe_n} = 4'b1111;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk(dq_drive == 1'b0 && cyc_code == 3'd0 && page_cnt == 4'd0,
            $sformatf("R1 mid-run reset got drive %0b code %0d cnt %0d expected 0 0 0",
                      dq_drive, cyc_code, page_cnt));
        rst_n = 1'b1;
        repeat (6) @(posedge clk);
        @(negedge clk);
        chk(cyc_valid == 1'b0 && dq_drive == 1'b0,
            $sformatf("R1 after release got %0b%0b expected 00", cyc_valid, dq_drive));

        done = 1'b1;
        finish_run();
    end
endmodule